// File: doc/BRIEF.md
# Pipelined Parity-Checking Bus Register

This block sits on a 12-bit data path and presents that path on two identical output copies. A mode input picks one of two behaviours. In one, the inputs pass straight through to the outputs with no register in the way. In the other, the outputs show an internal word register that loads on the rising clock. A hold input protects the lower eight bits of that register. While hold is high, only the upper four bits load.

Parity for each data word reaches the block one clock after the word itself. The block keeps the XOR of the previous word in a register so that this late parity bit has a value to meet. The result goes into an error flag one clock later still. Data bit 10 also acts as the load enable for that flag. The flag is active low and modelled as open drain: it either pulls the line low or releases it.

A parity-role input decides what the shared parity pin does:
- When the role input is high, the pin is an input. It selects even or odd sense for a single block, or it accepts a partial sum from an upstream block.
- When the role input is low, the block drives its own partial sum out on the pin, so a second block can finish the check.

A single output-enable qualifies both output copies and the error line together.

Top module: `parbus_reg`

## Requirements
- R1: A synchronous reset clears the word register, the parity alignment register and the error flag. After reset, in register mode with outputs enabled, both copies read 0 and `err_drv` is 0.
- R2: With `bypass`=1 and `out_en`=1, both output copies equal `din` combinationally, in the same cycle.
- R3: With `bypass`=0 and `freeze_low`=0, a rising clock loads all 12 bits of `din` into the word register. The outputs show the new word after that edge.
- R4: With `freeze_low`=1, a rising clock loads only `din[11:8]`, and bits [7:0] of the word register keep their value. The word register loads by these rules in both modes.
- R5: `ya` always equals `yb`. With `out_en`=0, `ya`, `yb`, `y_oe` and `err_drv` are all 0. With `out_en`=1, `y_oe` is 1.
- R6: The word sampled at edge k is checked against `par_in` sampled at edge k+1. The mismatch is XOR(all 12 word bits) ^ `par_in` ^ s, where s = `pio_in` when `par_role`=1 and s = 0 when `par_role`=0. With `pio_in`=0 this is even parity; with `pio_in`=1 it is odd parity. The check runs in both modes and ignores `freeze_low`. The error flag takes the mismatch at edge k+1, and `err_drv` (1 = line pulled low) shows the flag whenever `out_en`=1.
- R7: The error flag loads only at an edge where `din[10]`=1. At an edge with `din[10]`=0, the flag keeps its value.
- R8: With `par_role`=0, `pio_oe`=1 and `pio_out` = XOR(the 12 bits of the word sampled at the previous edge) ^ `par_in`. This partial sum is what a downstream block's `pio_in` takes. With `par_role`=1, `pio_oe`=0 and `pio_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | 1 = transparent buffer, 0 = registered path |
| freeze_low | input | 1 | 1 = bits [7:0] of the word register hold |
| out_en | input | 1 | Enables both output copies and the error line |
| din | input | 12 | Data word; bit 10 also enables the error flag load |
| par_in | input | 1 | Parity bit, one cycle after its word |
| par_role | input | 1 | 1 = parity pin is an input, 0 = drive partial sum |
| pio_in | input | 1 | Parity pin value when used as input |
| ya | output | 12 | Output copy A |
| yb | output | 12 | Output copy B |
| y_oe | output | 1 | Output copies are driven |
| err_drv | output | 1 | 1 = error line pulled low |
| pio_out | output | 1 | Partial parity sum |
| pio_oe | output | 1 | Parity pin is driven |

## Verification
The hardest state to reach is a stale error flag that must survive a later parity result. Bit 10 is both the flag enable and a data bit. So the word that follows the checked one decides whether the result is kept, and that word's own bit 10 also feeds into the next parity sum. A directed sequence chains four words so that the flag is raised, then held through a correct parity presented with bit 10 clear, and then cleared. A sweep over all 32 combinations of the five control inputs, with pseudo-random words and parity bits, covers the freeze, mode, role and enable interplay against a cycle model.

// File: rtl/parbus_pkg.sv
package parbus_pkg;

    localparam int WORD_W     = 12;
    localparam int LOW_W      = 8;
    localparam int ERR_EN_BIT = 10;
    localparam int COPIES     = 2;

    typedef enum logic {
        ERR_CLEAR = 1'b0,
        ERR_RAISED = 1'b1
    } err_state_t;

    typedef struct packed {
        logic bypass;
        logic freeze_low;
        logic out_en;
        logic par_role;
    } ctrl_t;

endpackage

// File: rtl/parbus_capture.sv
module parbus_capture #(
    parameter int W     = parbus_pkg::WORD_W,
    parameter int LOW_W = parbus_pkg::LOW_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         freeze_low,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    localparam int HIGH_W = W - LOW_W;

    logic [LOW_W-1:0]  low_q;
    logic [HIGH_W-1:0] high_q;

    // lower field: held while freeze_low is high
    always_ff @(posedge clk) begin
        if (rst)
            low_q <= '0;
        else if (!freeze_low)
            low_q <= din[LOW_W-1:0];
    end

    // upper field: loads on every edge
    always_ff @(posedge clk) begin
        if (rst)
            high_q <= '0;
        else
            high_q <= din[W-1:LOW_W];
    end

    assign q = {high_q, low_q};

    assert_low_hold_R4: assert property (@(posedge clk) disable iff (rst)
        freeze_low |=> q[LOW_W-1:0] == $past(q[LOW_W-1:0]));

    assert_high_load_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> q[W-1:LOW_W] == $past(din[W-1:LOW_W]));

endmodule

// File: rtl/parbus_check.sv
module parbus_check #(
    parameter int W      = parbus_pkg::WORD_W,
    parameter int EN_BIT = parbus_pkg::ERR_EN_BIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         par_in,
    input  logic         par_role,
    input  logic         pio_in,
    output logic         flag,
    output logic         partial
);
    import parbus_pkg::*;

    logic       word_x_q;
    logic       sense;
    logic       mismatch;
    err_state_t err_q;

    // XOR of last cycle's word, aligned with the late parity bit
    always_ff @(posedge clk) begin
        if (rst)
            word_x_q <= 1'b0;
        else
            word_x_q <= ^din;
    end

    assign partial  = word_x_q ^ par_in;
    assign sense    = par_role ? pio_in : 1'b0;
    assign mismatch = partial ^ sense;

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= ERR_CLEAR;
        else if (din[EN_BIT])
            err_q <= mismatch ? ERR_RAISED : ERR_CLEAR;
    end

    assign flag = (err_q == ERR_RAISED);

    assert_err_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !din[EN_BIT] |=> $stable(flag));

    assert_err_check_R6: assert property (@(posedge clk) disable iff (rst)
        (din[EN_BIT] && !$past(rst)) |=>
            flag == ($past(^din, 2) ^ $past(par_in) ^ ($past(par_role) & $past(pio_in))));

endmodule

// File: rtl/parbus_drive.sv
module parbus_drive #(
    parameter int W      = parbus_pkg::WORD_W,
    parameter int COPIES = parbus_pkg::COPIES
) (
    input  logic                  bypass,
    input  logic                  out_en,
    input  logic [W-1:0]          din,
    input  logic [W-1:0]          q,
    input  logic                  flag,
    output logic [COPIES*W-1:0]   y_flat,
    output logic                  y_oe,
    output logic                  err_drv
);
    logic [W-1:0] sel;

    assign sel = bypass ? din : q;

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        assign y_flat[c*W +: W] = out_en ? sel : '0;
    end

    assign y_oe    = out_en;
    assign err_drv = out_en & flag;

endmodule

// File: rtl/parbus_reg.sv
module parbus_reg #(
    parameter int WORD_W     = parbus_pkg::WORD_W,
    parameter int LOW_W      = parbus_pkg::LOW_W,
    parameter int ERR_EN_BIT = parbus_pkg::ERR_EN_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bypass,
    input  logic              freeze_low,
    input  logic              out_en,
    input  logic [WORD_W-1:0] din,
    input  logic              par_in,
    input  logic              par_role,
    input  logic              pio_in,
    output logic [WORD_W-1:0] ya,
    output logic [WORD_W-1:0] yb,
    output logic              y_oe,
    output logic              err_drv,
    output logic              pio_out,
    output logic              pio_oe
);
    import parbus_pkg::*;

    localparam int NCOPY = 2;

    ctrl_t                    ctrl;
    logic [WORD_W-1:0]        word_q;
    logic                     flag;
    logic                     partial;
    logic [NCOPY*WORD_W-1:0]  y_flat;

    assign ctrl = '{bypass: bypass, freeze_low: freeze_low,
                    out_en: out_en, par_role: par_role};

    parbus_capture #(.W(WORD_W), .LOW_W(LOW_W)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .freeze_low (ctrl.freeze_low),
        .din        (din),
        .q          (word_q)
    );

    parbus_check #(.W(WORD_W), .EN_BIT(ERR_EN_BIT)) u_check (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .par_in   (par_in),
        .par_role (ctrl.par_role),
        .pio_in   (pio_in),
        .flag     (flag),
        .partial  (partial)
    );

    parbus_drive #(.W(WORD_W), .COPIES(NCOPY)) u_drive (
        .bypass  (ctrl.bypass),
        .out_en  (ctrl.out_en),
        .din     (din),
        .q       (word_q),
        .flag    (flag),
        .y_flat  (y_flat),
        .y_oe    (y_oe),
        .err_drv (err_drv)
    );

    assign ya      = y_flat[WORD_W-1:0];
    assign yb      = y_flat[2*WORD_W-1:WORD_W];
    assign pio_oe  = ~ctrl.par_role;
    assign pio_out = ctrl.par_role ? 1'b0 : partial;

    always_comb begin
        assert_copies_match_R5: assert (ya == yb);
        if (!out_en)
            assert_disabled_quiet_R5: assert (ya == '0 && !err_drv && !y_oe);
        if (bypass && out_en)
            assert_bypass_pass_R2: assert (ya == din);
    end

endmodule

// File: tb/test_parbus_reg.sv
`timescale 1ns/1ps
module test_parbus_reg;

    logic        clk = 1'b0;
    logic        rst;
    logic        bypass, freeze_low, out_en, par_in, par_role, pio_in;
    logic [11:0] din;
    logic [11:0] ya, yb;
    logic        y_oe, err_drv, pio_out, pio_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench cycle model, built from the requirements
    logic [11:0] m_q;
    logic        m_x;
    logic        m_err;

    always #2.5 clk = ~clk;

    parbus_reg i_parbus_reg (
        .clk(clk), .rst(rst), .bypass(bypass), .freeze_low(freeze_low),
        .out_en(out_en), .din(din), .par_in(par_in), .par_role(par_role),
        .pio_in(pio_in), .ya(ya), .yb(yb), .y_oe(y_oe), .err_drv(err_drv),
        .pio_out(pio_out), .pio_oe(pio_oe)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_q   <= '0;
            m_x   <= 1'b0;
            m_err <= 1'b0;
        end else begin
            m_q[11:8] <= din[11:8];
            if (!freeze_low) m_q[7:0] <= din[7:0];
            m_x <= ^din;
            if (din[10]) m_err <= m_x ^ par_in ^ (par_role & pio_in);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_model();
        logic [11:0] ey;
        ey = out_en ? (bypass ? din : m_q) : 12'h000;
        chk("R2/R3/R4 ya", {20'd0, ya}, {20'd0, ey});
        chk("R5 yb", {20'd0, yb}, {20'd0, ey});
        chk("R5 y_oe", {31'd0, y_oe}, {31'd0, out_en});
        chk("R6 err_drv", {31'd0, err_drv}, {31'd0, m_err & out_en});
        chk("R8 pio_oe", {31'd0, pio_oe}, {31'd0, ~par_role});
        chk("R8 pio_out", {31'd0, pio_out}, {31'd0, par_role ? 1'b0 : (m_x ^ par_in)});
    endtask

    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        return t ^ (t << 5);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        rst = 1'b1; bypass = 0; freeze_low = 0; out_en = 1;
        din = 12'hFFF; par_in = 1; par_role = 1; pio_in = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        din = 12'h000; par_in = 0;
        // R1: reset state seen before any further edge
        chk("R1 ya after reset", {20'd0, ya}, 32'd0);
        chk("R1 err_drv after reset", {31'd0, err_drv}, 32'd0);

        // R4: load A fully, then B with lower field frozen
        din = 12'h5A3;
        @(negedge clk);
        chk("R3 full load", {20'd0, ya}, 32'h5A3);
        din = 12'hC3C; freeze_low = 1;
        @(negedge clk);
        chk("R4 frozen low byte", {20'd0, ya}, 32'hCA3);
        freeze_low = 0;

        // R6/R7: raise, hold through a disabled load, then clear
        din = 12'h001; par_in = 0;
        @(negedge clk);
        din = 12'h400; par_in = 0;           // checks 001: xor 1 -> mismatch, enabled
        @(negedge clk);
        chk("R6 flag raised", {31'd0, err_drv}, 32'd1);
        din = 12'h000; par_in = 1;           // checks 400: correct, but bit10 clear
        @(negedge clk);
        chk("R7 flag held", {31'd0, err_drv}, 32'd1);
        din = 12'h400; par_in = 0;           // checks 000: correct, enabled
        @(negedge clk);
        chk("R7 flag cleared", {31'd0, err_drv}, 32'd0);
        out_en = 0;
        #1 chk("R5 disabled err", {31'd0, err_drv}, 32'd0);
        out_en = 1;

        // sweep over every control combination with pseudo-random data
        seed = 32'h1234_5678;
        for (int c = 0; c < 32; c++) begin
            {bypass, freeze_low, par_role, pio_in, out_en} = c[4:0];
            for (int k = 0; k < 40; k++) begin
                seed   = xs(seed);
                din    = seed[11:0];
                par_in = seed[20];
                #1 check_model();
                @(negedge clk);
                check_model();
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule